// File: doc/BRIEF.md
# Servo Loop Processor Core

This block is a compact Harvard-architecture processor for periodic control loops such as focus, spindle, seek and tracking filters. It has three private memories. A program store holds 24-bit instructions. A variable store holds 20-bit signed working values. A constant store holds 20-bit signed filter coefficients. The execute stage has its own read path into each memory. All arithmetic runs on a 20-bit signed accumulator.

The processor has a two-stage pipeline: fetch, then execute. Operands are read from the stores and results are written back within the same execute cycle, so every instruction sees the result of the one before it. The pipeline has no hazard, forwarding or stall logic. Almost every instruction takes one cycle. A taken branch costs one extra cycle, because the instruction already fetched behind it is thrown away.

A testbench or boot agent fills the memories through one load port with a target select. It pulses `start`, waits for `done`, and reads results through an observation port and the accumulator and flag outputs. An instruction word is `{opcode[23:20], var_addr[19:12], coef_addr[11:4], mode[3:0]}`.

Top module: `servo_core`

## Requirements
- R1: After reset, `done`, `flag_z`, `flag_n` and `acc_out` are 0 and no instruction executes until `start` is pulsed.
- R2: When `load_we` is high, the store chosen by `load_sel` (0 = program, 1 = variable, 2 = coefficient, 3 = none) takes `load_data` at `load_addr` on the clock edge. `obs_data` shows variable word `obs_addr` when `obs_sel` = 0 and coefficient word `obs_addr` when `obs_sel` = 1, without delay.
- R3: A `start` pulse sampled at edge E0 starts fetch at program address 0. In straight-line code, the instruction at address i executes at edge E0+i+2.
- R4: Opcode 1 loads the accumulator from variable[var_addr]. Opcode 2 loads it from coefficient[coef_addr]. Opcode 3 stores the accumulator into variable[var_addr]. A stored value is visible to the very next instruction.
- R5: Opcode 4 (add) and opcode 5 (subtract) combine the accumulator with variable[var_addr] when mode bit 0 is 0, or with coefficient[coef_addr] when mode bit 0 is 1. The result saturates to the range -2^19 to 2^19-1.
- R6: Add and subtract set `flag_z` when the saturated result is zero and set `flag_n` to its sign bit. No other instruction changes either flag.
- R7: Opcode 6 loads the accumulator with bits [38:19] of the signed 40-bit product variable[var_addr] × coefficient[coef_addr]. This is a fractional multiply. The single overflowing case, -2^19 × -2^19, gives 2^19-1.
- R8: Opcode 8 jumps unconditionally. Opcode 9 jumps when `flag_z` is set and opcode 10 jumps when `flag_n` is set. The target is the var_addr field. A taken jump discards the instruction fetched behind it and costs one extra cycle. A jump that is not taken costs nothing.
- R9: Opcode 15 raises `done` and stops fetch. The instruction behind it does not execute. `done`, the accumulator and the stores then hold until the next `start`, which clears `done`.
- R10: Opcode 0 and the unassigned opcodes 7 and 11 to 14 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin execution at program address 0 |
| load_we | input | 1 | Load-port write strobe |
| load_sel | input | 2 | Load target: 0 program, 1 variable, 2 coefficient |
| load_addr | input | 8 | Load address |
| load_data | input | 24 | Load data; the data stores take bits [19:0] |
| obs_sel | input | 1 | Observation source: 0 variable, 1 coefficient |
| obs_addr | input | 8 | Observation address |
| obs_data | output | 20 | Observed store word |
| acc_out | output | 20 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| done | output | 1 | Halt reached |

## Verification
Each program is loaded and then started. The bench counts rising edges from the start edge to the first edge at which `done` is seen, sampling at falling edges. A straight-line program whose halt sits at address h must report h+2 edges, and each taken jump must add one. After `done`, stores and flags are read through the observation port and the flag outputs, which are valid half a cycle after the last write-back. Loads take effect at the single rising edge between two falling edges, and the observation port is read without delay, so both are checked at the next falling edge.

// File: rtl/servo_pkg.sv
`timescale 1ns/1ps
// servo_pkg: opcodes and load-target codes shared by the servo core.
// Assumes a 4-bit opcode in the top bits of each instruction word.
package servo_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_LDV = 4'd1,
        OP_LDC = 4'd2,
        OP_STV = 4'd3,
        OP_ADD = 4'd4,
        OP_SUB = 4'd5,
        OP_MUL = 4'd6,
        OP_JMP = 4'd8,
        OP_JZ  = 4'd9,
        OP_JN  = 4'd10,
        OP_HLT = 4'd15
    } op_e;

    localparam logic [1:0] TGT_PROG = 2'd0;
    localparam logic [1:0] TGT_VAR  = 2'd1;
    localparam logic [1:0] TGT_COEF = 2'd2;

endpackage

// File: rtl/servo_mem.sv
`timescale 1ns/1ps
// servo_mem: data store with one synchronous write port and two
// asynchronous read ports (execute path and observation path).
// Assumes the contents need no reset; software fills them before use.
module servo_mem #(
    parameter int AW = 8,
    parameter int DW = 20
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write one word per clock when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Both read ports are combinational.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/servo_fetch.sv
`timescale 1ns/1ps
// servo_fetch: program store, program counter and the fetch register.
// Assumes that kill comes from the execute stage in the same cycle and
// that start has priority over everything else.
module servo_fetch #(
    parameter int AW = 8,
    parameter int IW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic          kill,
    input  logic          redirect,
    input  logic [AW-1:0] tgt,
    input  logic          imem_we,
    input  logic [AW-1:0] imem_addr,
    input  logic [IW-1:0] imem_data,
    output logic [IW-1:0] if_instr,
    output logic          if_valid
);
    localparam int DEPTH = 1 << AW;

    logic [IW-1:0] imem [DEPTH];
    logic [AW-1:0] pc;

    // Program store write from the load port.
    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_addr] <= imem_data;
    end

    // Program counter and fetch register, with flush on kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            if_instr <= '0;
            if_valid <= 1'b0;
        end else if (start) begin
            pc       <= '0;
            if_valid <= 1'b0;
        end else if (!run) begin
            if_valid <= 1'b0;
        end else if (kill) begin
            if_valid <= 1'b0;
            if (redirect) pc <= tgt;
        end else begin
            if_instr <= imem[pc];
            if_valid <= 1'b1;
            pc       <= pc + 1'b1;
        end
    end

    AST_KILL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kill) |=> !if_valid);  // R8
    AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> !if_valid);  // R9
endmodule

// File: rtl/servo_alu.sv
`timescale 1ns/1ps
// servo_alu: combinational result and flag generation for the execute
// stage. Assumes two's-complement operands of width DW.
module servo_alu
    import servo_pkg::*;
#(
    parameter int DW = 20
) (
    input  op_e           op,
    input  logic          src_coef,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] var_rd,
    input  logic [DW-1:0] coef_rd,
    output logic [DW-1:0] res,
    output logic          acc_we,
    output logic          flag_we
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0]          opb;
    logic signed [DW:0]     sum;
    logic signed [2*DW-1:0] prod;

    // Operand choice, widened sum/difference and full product.
    always_comb begin
        opb  = src_coef ? coef_rd : var_rd;
        sum  = (op == OP_SUB) ? ($signed({acc[DW-1], acc}) - $signed({opb[DW-1], opb}))
                              : ($signed({acc[DW-1], acc}) + $signed({opb[DW-1], opb}));
        prod = $signed(var_rd) * $signed(coef_rd);
    end

    // Result selection with saturation.
    always_comb begin
        res     = acc;
        acc_we  = 1'b0;
        flag_we = 1'b0;
        unique case (op)
            OP_LDV: begin res = var_rd;  acc_we = 1'b1; end
            OP_LDC: begin res = coef_rd; acc_we = 1'b1; end
            OP_ADD, OP_SUB: begin
                acc_we  = 1'b1;
                flag_we = 1'b1;
                if (sum[DW] != sum[DW-1]) res = sum[DW] ? SMIN : SMAX;
                else                      res = sum[DW-1:0];
            end
            OP_MUL: begin
                acc_we = 1'b1;
                if (prod[2*DW-1] != prod[2*DW-2]) res = SMAX;
                else                              res = prod[2*DW-2:DW-1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/servo_core.sv
`timescale 1ns/1ps
// servo_core: two-stage servo loop processor. Fetch fills one register;
// execute reads the stores, computes and writes back in the same cycle,
// so the next instruction sees every result. Assumes the memories are
// loaded before start; a taken jump or halt flushes the fetch register.
module servo_core
    import servo_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 20,
    parameter int OPW = 4,
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          load_we,
    input  logic [1:0]    load_sel,
    input  logic [AW-1:0] load_addr,
    input  logic [OPW+2*AW+MW-1:0] load_data,
    input  logic          obs_sel,
    input  logic [AW-1:0] obs_addr,
    output logic [DW-1:0] obs_data,
    output logic [DW-1:0] acc_out,
    output logic          flag_z,
    output logic          flag_n,
    output logic          done
);
    localparam int IW    = OPW + 2*AW + MW;
    localparam int VA_LO = AW + MW;
    localparam int CA_LO = MW;

    logic [IW-1:0] if_instr;
    logic          if_valid;
    logic          running;
    logic [DW-1:0] acc;
    op_e           op;
    logic [AW-1:0] va, ca;
    logic          ex_valid, taken, kill;
    logic [DW-1:0] var_rd, coef_rd, var_obs, coef_obs;
    logic [DW-1:0] alu_res;
    logic          alu_acc_we, alu_flag_we;
    logic          var_we;
    logic [AW-1:0] var_waddr;
    logic [DW-1:0] var_wdata;
    logic          unused_mode;

    // Instruction field decode.
    assign op          = op_e'(if_instr[IW-1 -: OPW]);
    assign va          = if_instr[VA_LO +: AW];
    assign ca          = if_instr[CA_LO +: AW];
    assign unused_mode = ^if_instr[MW-1:1];
    assign ex_valid    = running && if_valid && !start;

    // Branch resolution and fetch flush.
    always_comb begin
        taken = ex_valid && ((op == OP_JMP) || (op == OP_JZ && flag_z) ||
                             (op == OP_JN && flag_n));
        kill  = taken || (ex_valid && op == OP_HLT);
    end

    servo_fetch #(.AW(AW), .IW(IW)) i_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .run      (running),
        .kill     (kill),
        .redirect (taken),
        .tgt      (va),
        .imem_we  (load_we && load_sel == TGT_PROG),
        .imem_addr(load_addr),
        .imem_data(load_data),
        .if_instr (if_instr),
        .if_valid (if_valid)
    );

    // Variable store write: execute store wins over the load port.
    always_comb begin
        if (ex_valid && op == OP_STV) begin
            var_we    = 1'b1;
            var_waddr = va;
            var_wdata = acc;
        end else begin
            var_we    = load_we && load_sel == TGT_VAR;
            var_waddr = load_addr;
            var_wdata = load_data[DW-1:0];
        end
    end

    servo_mem #(.AW(AW), .DW(DW)) i_var_mem (
        .clk    (clk),
        .we     (var_we),
        .waddr  (var_waddr),
        .wdata  (var_wdata),
        .raddr_a(va),
        .rdata_a(var_rd),
        .raddr_b(obs_addr),
        .rdata_b(var_obs)
    );

    servo_mem #(.AW(AW), .DW(DW)) i_coef_mem (
        .clk    (clk),
        .we     (load_we && load_sel == TGT_COEF),
        .waddr  (load_addr),
        .wdata  (load_data[DW-1:0]),
        .raddr_a(ca),
        .rdata_a(coef_rd),
        .raddr_b(obs_addr),
        .rdata_b(coef_obs)
    );

    servo_alu #(.DW(DW)) i_alu (
        .op      (op),
        .src_coef(if_instr[0]),
        .acc     (acc),
        .var_rd  (var_rd),
        .coef_rd (coef_rd),
        .res     (alu_res),
        .acc_we  (alu_acc_we),
        .flag_we (alu_flag_we)
    );

    // Accumulator, flags and run/done control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            flag_z  <= 1'b0;
            flag_n  <= 1'b0;
            running <= 1'b0;
            done    <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
            done    <= 1'b0;
        end else if (ex_valid) begin
            if (alu_acc_we) acc <= alu_res;
            if (alu_flag_we) begin
                flag_z <= (alu_res == '0);
                flag_n <= alu_res[DW-1];
            end
            if (op == OP_HLT) begin
                running <= 1'b0;
                done    <= 1'b1;
            end
        end
    end

    assign acc_out  = acc;
    assign obs_data = obs_sel ? coef_obs : var_obs;

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(acc)));  // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);  // R9
    AST_FLAGS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && (op == OP_ADD || op == OP_SUB)) |=> ((flag_z == (acc == '0)) && (flag_n == acc[DW-1])));  // R6
    AST_ADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && op == OP_ADD && !acc[DW-1] && !(if_instr[0] ? coef_rd[DW-1] : var_rd[DW-1])) |=> !acc[DW-1]);  // R5
    AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && op != OP_ADD && op != OP_SUB) |=> ($stable(flag_z) && $stable(flag_n)));  // R6
endmodule

// File: tb/test_servo_core.sv
`timescale 1ns/1ps
module test_servo_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        load_we = 1'b0;
    logic [1:0]  load_sel = 2'd0;
    logic [7:0]  load_addr = 8'd0;
    logic [23:0] load_data = 24'd0;
    logic        obs_sel = 1'b0;
    logic [7:0]  obs_addr = 8'd0;
    logic [19:0] obs_data, acc_out;
    logic        flag_z, flag_n, done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    servo_core i_servo_core (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_we(load_we), .load_sel(load_sel), .load_addr(load_addr),
        .load_data(load_data), .obs_sel(obs_sel), .obs_addr(obs_addr),
        .obs_data(obs_data), .acc_out(acc_out), .flag_z(flag_z),
        .flag_n(flag_n), .done(done)
    );

    function automatic logic [23:0] enc(input int op, input int va, input int ca, input int md);
        return {op[3:0], va[7:0], ca[7:0], md[3:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] sel, input int addr, input logic [23:0] data);
        @(negedge clk);
        load_we = 1'b1; load_sel = sel; load_addr = addr[7:0]; load_data = data;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic peek(input bit sel, input int addr, output logic [19:0] val);
        @(negedge clk);
        obs_sel = sel; obs_addr = addr[7:0];
        #1 val = obs_data;
    endtask

    task automatic run_prog(input string req, output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        chk({req, " done cleared by start"}, done, 0);
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset;
        chk("R1 done", done, 0);
        chk("R1 acc", acc_out, 0);
        chk("R1 flag_z", flag_z, 0);
        chk("R1 flag_n", flag_n, 0);
        repeat (5) @(negedge clk);
        chk("R1 idle acc", acc_out, 0);
        chk("R1 idle done", done, 0);
    endtask

    task automatic t_load;
        logic [19:0] v;
        put(2'd1, 5, 24'h012345);
        put(2'd2, 7, 24'h0ABCDE);
        put(2'd3, 5, 24'h055555);
        peek(1'b0, 5, v); chk("R2 var readback", v, 20'h12345);
        peek(1'b1, 7, v); chk("R2 coef readback", v, 20'hABCDE);
    endtask

    task automatic t_move;
        int c; logic [19:0] v;
        put(2'd0, 0, enc(1, 5, 0, 0));
        put(2'd0, 1, enc(3, 9, 0, 0));
        put(2'd0, 2, enc(2, 0, 7, 0));
        put(2'd0, 3, enc(3, 10, 0, 0));
        put(2'd0, 4, enc(15, 0, 0, 0));
        run_prog("R9", c);
        chk("R3 straight-line cycles", c, 6);
        peek(1'b0, 9, v);  chk("R4 store after load", v, 20'h12345);
        peek(1'b0, 10, v); chk("R4 coef move", v, 20'hABCDE);
        chk("R4 acc", acc_out, 20'hABCDE);
    endtask

    task automatic t_arith;
        int c; logic [19:0] v;
        put(2'd1, 1, 24'h07FFF0);
        put(2'd1, 2, 24'h000100);
        put(2'd2, 3, 24'h000005);
        put(2'd1, 4, 24'h080010);
        put(2'd0, 0, enc(1, 1, 0, 0));
        put(2'd0, 1, enc(4, 2, 0, 0));
        put(2'd0, 2, enc(3, 20, 0, 0));
        put(2'd0, 3, enc(5, 1, 0, 0));
        put(2'd0, 4, enc(3, 21, 0, 0));
        put(2'd0, 5, enc(4, 0, 3, 1));
        put(2'd0, 6, enc(15, 0, 0, 0));
        run_prog("R9", c);
        chk("R3 cycles arith", c, 8);
        peek(1'b0, 20, v); chk("R5 positive saturation", v, 20'h7FFFF);
        peek(1'b0, 21, v); chk("R5 subtract", v, 20'h0000F);
        chk("R5 add coef operand", acc_out, 20'h00014);
        chk("R6 z clear", flag_z, 0);
        chk("R6 n clear", flag_n, 0);
        put(2'd0, 0, enc(1, 4, 0, 0));
        put(2'd0, 1, enc(5, 2, 0, 0));
        put(2'd0, 2, enc(15, 0, 0, 0));
        run_prog("R9", c);
        chk("R5 negative saturation", acc_out, 20'h80000);
        chk("R6 n set", flag_n, 1);
        chk("R6 z clear neg", flag_z, 0);
        put(2'd0, 0, enc(1, 1, 0, 0));
        put(2'd0, 1, enc(5, 1, 0, 0));
        put(2'd0, 2, enc(2, 0, 3, 0));
        put(2'd0, 3, enc(15, 0, 0, 0));
        run_prog("R9", c);
        chk("R6 z kept after load", flag_z, 1);
        chk("R6 n after zero", flag_n, 0);
        chk("R4 acc after load", acc_out, 20'h00005);
    endtask

    task automatic t_mul;
        int c; logic [19:0] v;
        put(2'd1, 6, 24'h040000);
        put(2'd2, 8, 24'h040000);
        put(2'd2, 13, 24'h0C0000);
        put(2'd1, 11, 24'h080000);
        put(2'd2, 12, 24'h080000);
        put(2'd0, 0, enc(1, 1, 0, 0));
        put(2'd0, 1, enc(5, 1, 0, 0));
        put(2'd0, 2, enc(6, 6, 8, 0));
        put(2'd0, 3, enc(3, 30, 0, 0));
        put(2'd0, 4, enc(6, 6, 13, 0));
        put(2'd0, 5, enc(3, 31, 0, 0));
        put(2'd0, 6, enc(6, 11, 12, 0));
        put(2'd0, 7, enc(3, 32, 0, 0));
        put(2'd0, 8, enc(15, 0, 0, 0));
        run_prog("R9", c);
        chk("R3 cycles mul", c, 10);
        peek(1'b0, 30, v); chk("R7 half times half", v, 20'h20000);
        peek(1'b0, 31, v); chk("R7 negative product", v, 20'hE0000);
        peek(1'b0, 32, v); chk("R7 overflow saturates", v, 20'h7FFFF);
        chk("R6 flags kept by mul", {flag_z, flag_n}, 2'b10);
    endtask

    task automatic t_branch;
        int c; logic [19:0] v;
        put(2'd1, 40, 24'h0);
        put(2'd1, 41, 24'h0);
        put(2'd0, 0, enc(2, 0, 3, 0));
        put(2'd0, 1, enc(8, 4, 0, 0));
        put(2'd0, 2, enc(3, 40, 0, 0));
        put(2'd0, 3, enc(15, 0, 0, 0));
        put(2'd0, 4, enc(3, 41, 0, 0));
        put(2'd0, 5, enc(15, 0, 0, 0));
        run_prog("R9", c);
        chk("R8 jump costs one cycle", c, 6);
        peek(1'b0, 40, v); chk("R8 slot discarded", v, 20'h0);
        peek(1'b0, 41, v); chk("R8 target executed", v, 20'h5);
        put(2'd1, 42, 24'h011111);
        put(2'd1, 43, 24'h011111);
        put(2'd1, 44, 24'h022222);
        put(2'd0, 0, enc(1, 1, 0, 0));
        put(2'd0, 1, enc(5, 1, 0, 0));
        put(2'd0, 2, enc(10, 5, 0, 0));
        put(2'd0, 3, enc(9, 6, 0, 0));
        put(2'd0, 4, enc(3, 42, 0, 0));
        put(2'd0, 5, enc(3, 43, 0, 0));
        put(2'd0, 6, enc(3, 44, 0, 0));
        put(2'd0, 7, enc(15, 0, 0, 0));
        run_prog("R9", c);
        chk("R8 conditional cycles", c, 8);
        peek(1'b0, 42, v); chk("R8 jz discards slot", v, 20'h11111);
        peek(1'b0, 43, v); chk("R8 jn not taken skips nothing wrong", v, 20'h11111);
        peek(1'b0, 44, v); chk("R8 jz target", v, 20'h0);
    endtask

    task automatic t_halt;
        int c; logic [19:0] v;
        put(2'd1, 50, 24'h033333);
        put(2'd1, 51, 24'h044444);
        put(2'd0, 0, enc(2, 0, 3, 0));
        put(2'd0, 1, enc(0, 50, 0, 0));
        put(2'd0, 2, enc(7, 50, 0, 0));
        put(2'd0, 3, enc(12, 50, 0, 1));
        put(2'd0, 4, enc(15, 0, 0, 0));
        put(2'd0, 5, enc(3, 51, 0, 0));
        run_prog("R9", c);
        chk("R10 cycles with nops", c, 6);
        chk("R10 acc unchanged", acc_out, 20'h00005);
        chk("R10 flags unchanged", {flag_z, flag_n}, 2'b10);
        peek(1'b0, 50, v); chk("R10 store untouched", v, 20'h33333);
        peek(1'b0, 51, v); chk("R9 post-halt slot not run", v, 20'h44444);
        repeat (5) @(negedge clk);
        chk("R9 done held", done, 1);
        chk("R9 acc frozen", acc_out, 20'h00005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_move();
        t_arith();
        t_mul();
        t_branch();
        t_halt();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule